// File: doc/BRIEF.md
# Cartridge CPU-Side Bank Register and Decoder

This block sits between the console CPU bus and the program ROM of a discrete-logic cartridge. It watches the ROM-select strobe, the read/write line and CPU address bit 14 for accesses to the upper 32 KB of CPU space. From these it drives three things: the program ROM output-enable, the program ROM write-enable, and an 8-bit bank register. The register supplies the upper ROM address lines, two character-RAM bank bits and a one-screen mirroring select. The picture-side decoder consumes those last three bits.

A static input, `cfg_flash`, picks one of two builds. In the fixed build, every write in the window loads the register. The value stored is the CPU byte ANDed with the ROM byte at that address, which models the bus conflict between CPU and ROM. In the self-flashable build, only writes to the upper 16 KB load the register, and those loads take the CPU byte unchanged. A write to the lower 16 KB becomes a ROM write strobe, and when `HAS_LED` is set it also latches the byte into an indicator output register. The parameter `PRG_BITS` sets how many upper ROM address lines exist: 5 for a 512 KB part, 4 for a 256 KB part.

A small access-classifier state machine runs on the system clock and takes one of four states:
- `ACC_IDLE`: no ROM select.
- `ACC_READ`: a read in the window.
- `ACC_LOAD`: a register-loading write.
- `ACC_FLASH`: a ROM-programming write.

On every clock the next state is the class of the current access, so any state can move to any other. A register load fires only on the transition into `ACC_LOAD` from another state. An indicator load fires only on the transition into `ACC_FLASH` from another state. As a result, a strobe held over several clocks acts once.

Top module: `mpr_cpu_decode`

## Requirements
- R1: After reset, the bank register and the indicator register are zero. So with `cpu_a14`=0, `prg_hi`, `chr_bank`, `one_screen` and `led_q` all read 0.
- R2: Each upper ROM address line `prg_hi[i]` is `cpu_a14` OR bank bit i. With `cpu_a14`=1, every line is 1, so the upper 16 KB always shows the last bank.
- R3: With `cfg_flash`=0, a write (`rom_sel_n`=0, `cpu_rw`=0) at either value of `cpu_a14` loads the bank register with `cpu_data & rom_data`.
- R4: With `cfg_flash`=1, a write with `cpu_a14`=1 loads the bank register with `cpu_data` unmodified, whatever `rom_data` holds.
- R5: With `cfg_flash`=1, a write with `cpu_a14`=0 drives `rom_we_n` low in that same cycle and leaves the bank register unchanged.
- R6: With `cfg_flash`=0, `rom_we_n` stays high at all times.
- R7: `rom_oe_n` is low exactly when `rom_sel_n`=0 and `cpu_rw`=1. In the same cycle it is combinational from those inputs.
- R8: Field decode of the bank register: bit 7 drives `one_screen`, bits 6:5 drive `chr_bank`, and bits 4:0 are the program bank.
- R9: The register changes on the first clock edge of a write strobe and not within that cycle. If the strobe is held over further clocks, those clocks have no effect, even when `cpu_data` changes.
- R10: With `HAS_LED`=1 and `cfg_flash`=1, a lower-half write latches `cpu_data` into `led_q`. Upper-half writes and all writes with `cfg_flash`=0 leave `led_q` unchanged.
- R11: With `PRG_BITS`=4, only bank bits 3:0 reach the ROM address, so bank bit 4 has no effect.
- R12: With `rom_sel_n`=1, nothing loads, whatever `cpu_rw` and `cpu_data` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_flash | input | 1 | Static build select: 1 = self-flashable |
| cpu_a14 | input | 1 | CPU address bit 14 |
| cpu_rw | input | 1 | CPU read (1) / write (0) |
| rom_sel_n | input | 1 | Active-low ROM window select |
| cpu_data | input | 8 | CPU write data |
| rom_data | input | 8 | ROM byte at the current address (bus-conflict input) |
| prg_hi | output | PRG_BITS | Upper program ROM address lines |
| rom_we_n | output | 1 | Program ROM write-enable, active low |
| rom_oe_n | output | 1 | Program ROM output-enable, active low |
| chr_bank | output | 2 | Character RAM bank select |
| one_screen | output | 1 | One-screen mirroring select |
| led_q | output | 8 | Indicator register |

## Verification
The enables `rom_oe_n` and `rom_we_n`, and the `cpu_a14` term of `prg_hi`, are due in the same cycle as the access. The bench samples them 2 ns after driving the inputs at the falling edge. A register load or indicator load shows on the outputs right after the next rising edge. The reference model updates its bank and indicator values only at that edge, using its own record of the previous access class, so the checks one cycle later expect the new value. Held strobes, idle cycles with the write line low, and writes to both halves in both builds are each compared cycle by cycle.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
    localparam int BANK_W     = 8;
    localparam int MIRROR_BIT = 7;
    localparam int CHR_LSB    = 5;
    localparam int CHR_W      = 2;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_LOAD  = 2'd2,
        ACC_FLASH = 2'd3
    } acc_t;
endpackage

// File: rtl/mpr_access_fsm.sv
module mpr_access_fsm
    import mpr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_flash,
    input  logic cpu_a14,
    input  logic cpu_rw,
    input  logic rom_sel_n,
    output logic load_pulse,
    output logic flash_pulse,
    output logic rom_we_n,
    output logic rom_oe_n
);
    acc_t state_q;
    acc_t cls;

    // Classify the access currently on the bus.
    always_comb begin
        if (rom_sel_n) begin
            cls = ACC_IDLE;
        end else if (cpu_rw) begin
            cls = ACC_READ;
        end else if (!cfg_flash || cpu_a14) begin
            cls = ACC_LOAD;
        end else begin
            cls = ACC_FLASH;
        end
    end

    // State register: remembers the class of the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
        end else begin
            state_q <= cls;
        end
    end

    // Outputs: strobes follow the present class, loads fire on entry.
    always_comb begin
        rom_we_n    = 1'b1;
        rom_oe_n    = 1'b1;
        load_pulse  = 1'b0;
        flash_pulse = 1'b0;
        unique case (cls)
            ACC_IDLE: begin
            end
            ACC_READ: begin
                rom_oe_n = 1'b0;
            end
            ACC_LOAD: begin
                load_pulse = (state_q != ACC_LOAD);
            end
            ACC_FLASH: begin
                rom_we_n    = 1'b0;
                flash_pulse = (state_q != ACC_FLASH);
            end
        endcase
    end
endmodule

// File: rtl/mpr_bank_reg.sv
module mpr_bank_reg
    import mpr_pkg::*;
#(
    parameter bit HAS_LED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_flash,
    input  logic              load_pulse,
    input  logic              flash_pulse,
    input  logic [BANK_W-1:0] cpu_data,
    input  logic [BANK_W-1:0] rom_data,
    output logic [BANK_W-1:0] bank_q,
    output logic [BANK_W-1:0] led_q
);
    logic [BANK_W-1:0] load_val;

    // Fixed build: ROM drives the bus too, so open-collector style AND.
    assign load_val = cfg_flash ? cpu_data : (cpu_data & rom_data);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (load_pulse) begin
            bank_q <= load_val;
        end
    end

    generate
        if (HAS_LED) begin : g_led
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    led_q <= '0;
                end else if (flash_pulse) begin
                    led_q <= cpu_data;
                end
            end
        end else begin : g_no_led
            assign led_q = '0;
        end
    endgenerate
endmodule

// File: rtl/mpr_rom_addr.sv
module mpr_rom_addr #(
    parameter int PRG_BITS = 5
) (
    input  logic                cpu_a14,
    input  logic [PRG_BITS-1:0] bank_bits,
    output logic [PRG_BITS-1:0] prg_hi
);
    generate
        for (genvar i = 0; i < PRG_BITS; i++) begin : g_line
            assign prg_hi[i] = cpu_a14 | bank_bits[i];
        end
    endgenerate
endmodule

// File: rtl/mpr_cpu_decode.sv
module mpr_cpu_decode
    import mpr_pkg::*;
#(
    parameter int PRG_BITS = 5,
    parameter bit HAS_LED  = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_flash,
    input  logic                cpu_a14,
    input  logic                cpu_rw,
    input  logic                rom_sel_n,
    input  logic [7:0]          cpu_data,
    input  logic [7:0]          rom_data,
    output logic [PRG_BITS-1:0] prg_hi,
    output logic                rom_we_n,
    output logic                rom_oe_n,
    output logic [1:0]          chr_bank,
    output logic                one_screen,
    output logic [7:0]          led_q
);
    logic              load_pulse;
    logic              flash_pulse;
    logic [BANK_W-1:0] bank_q;

    mpr_access_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_flash   (cfg_flash),
        .cpu_a14     (cpu_a14),
        .cpu_rw      (cpu_rw),
        .rom_sel_n   (rom_sel_n),
        .load_pulse  (load_pulse),
        .flash_pulse (flash_pulse),
        .rom_we_n    (rom_we_n),
        .rom_oe_n    (rom_oe_n)
    );

    mpr_bank_reg #(.HAS_LED(HAS_LED)) u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_flash   (cfg_flash),
        .load_pulse  (load_pulse),
        .flash_pulse (flash_pulse),
        .cpu_data    (cpu_data),
        .rom_data    (rom_data),
        .bank_q      (bank_q),
        .led_q       (led_q)
    );

    mpr_rom_addr #(.PRG_BITS(PRG_BITS)) u_addr (
        .cpu_a14   (cpu_a14),
        .bank_bits (bank_q[PRG_BITS-1:0]),
        .prg_hi    (prg_hi)
    );

    assign one_screen = bank_q[MIRROR_BIT];
    assign chr_bank   = bank_q[CHR_LSB +: CHR_W];
endmodule

// File: rtl/mpr_cpu_decode_chk.sv
module mpr_cpu_decode_chk #(
    parameter int PRG_BITS = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_flash,
    input logic                cpu_a14,
    input logic                cpu_rw,
    input logic                rom_sel_n,
    input logic [PRG_BITS-1:0] prg_hi,
    input logic                rom_we_n,
    input logic                rom_oe_n,
    input logic [1:0]          chr_bank,
    input logic                one_screen
);
    AST_UPPER_LAST_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_a14 |-> (&prg_hi)); // R2
    AST_WE_FIXED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_flash |-> rom_we_n); // R6
    AST_WE_NEEDS_LOWER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_we_n |-> (!rom_sel_n && !cpu_rw && !cpu_a14)); // R5
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rom_we_n && !rom_oe_n)); // R7
    AST_FLASH_KEEPS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_we_n |=> $stable({one_screen, chr_bank})); // R5
    AST_IDLE_KEEPS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel_n |=> $stable({one_screen, chr_bank})); // R12
    AST_READ_KEEPS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_oe_n) |=> $stable({one_screen, chr_bank})); // R7
endmodule

bind mpr_cpu_decode mpr_cpu_decode_chk #(.PRG_BITS(PRG_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_flash  (cfg_flash),
    .cpu_a14    (cpu_a14),
    .cpu_rw     (cpu_rw),
    .rom_sel_n  (rom_sel_n),
    .prg_hi     (prg_hi),
    .rom_we_n   (rom_we_n),
    .rom_oe_n   (rom_oe_n),
    .chr_bank   (chr_bank),
    .one_screen (one_screen)
);

// File: tb/tb_mpr_cpu_decode.sv
`timescale 1ns/1ps
module tb_mpr_cpu_decode;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_flash = 1'b0;
    logic       cpu_a14 = 1'b0;
    logic       cpu_rw = 1'b1;
    logic       rom_sel_n = 1'b1;
    logic [7:0] cpu_data = 8'h00;
    logic [7:0] rom_data = 8'hFF;

    logic [4:0] prg_hi;
    logic       rom_we_n, rom_oe_n, one_screen;
    logic [1:0] chr_bank;
    logic [7:0] led_q;
    logic [3:0] prg_hi_s;
    logic       we_s, oe_s, one_s;
    logic [1:0] chr_s;
    logic [7:0] led_s;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    int exp_bank = 0;
    int exp_led  = 0;
    int prev_kind = 0; // 0 none/read, 1 register load, 2 flash write

    always #5 clk = ~clk;

    mpr_cpu_decode dut (
        .clk(clk), .rst_n(rst_n), .cfg_flash(cfg_flash), .cpu_a14(cpu_a14),
        .cpu_rw(cpu_rw), .rom_sel_n(rom_sel_n), .cpu_data(cpu_data),
        .rom_data(rom_data), .prg_hi(prg_hi), .rom_we_n(rom_we_n),
        .rom_oe_n(rom_oe_n), .chr_bank(chr_bank), .one_screen(one_screen),
        .led_q(led_q)
    );

    mpr_cpu_decode #(.PRG_BITS(4), .HAS_LED(1'b0)) dut_small (
        .clk(clk), .rst_n(rst_n), .cfg_flash(cfg_flash), .cpu_a14(cpu_a14),
        .cpu_rw(cpu_rw), .rom_sel_n(rom_sel_n), .cpu_data(cpu_data),
        .rom_data(rom_data), .prg_hi(prg_hi_s), .rom_we_n(we_s),
        .rom_oe_n(oe_s), .chr_bank(chr_s), .one_screen(one_s),
        .led_q(led_s)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int kind_of(input bit fl, input bit a14, input bit rw, input bit seln);
        if (seln || rw) return 0;
        if (!fl || a14) return 1;
        return 2;
    endfunction

    // One bus cycle: drive at falling edge, compare combinational results,
    // then advance the model at the rising edge.
    task automatic step(input bit fl, input bit a14, input bit rw, input bit seln,
                        input logic [7:0] d, input logic [7:0] r);
        int k;
        int hi;
        @(negedge clk);
        cfg_flash = fl; cpu_a14 = a14; cpu_rw = rw; rom_sel_n = seln;
        cpu_data = d; rom_data = r;
        #2;
        k  = kind_of(fl, a14, rw, seln);
        hi = a14 ? 31 : (exp_bank & 31);
        chk("R7 rom_oe_n", rom_oe_n, (!seln && rw) ? 0 : 1);
        chk("R5/R6 rom_we_n", rom_we_n, (k == 2) ? 0 : 1);
        chk("R2 prg_hi", prg_hi, hi);
        chk("R8 chr_bank", chr_bank, (exp_bank >> 5) & 3);
        chk("R8 one_screen", one_screen, (exp_bank >> 7) & 1);
        chk("R10 led_q", led_q, exp_led);
        chk("R11 small prg_hi", prg_hi_s, a14 ? 15 : (exp_bank & 15));
        @(posedge clk);
        if (k == 1 && prev_kind != 1) exp_bank = fl ? int'(d) : int'(d & r);
        if (k == 2 && prev_kind != 2) exp_led = d;
        prev_kind = k;
        #1;
    endtask

    task automatic idle(input bit fl);
        step(fl, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        idle(0);
        chk("R1 prg_hi", prg_hi, 0);
        chk("R1 chr_bank", chr_bank, 0);
        chk("R1 one_screen", one_screen, 0);
        chk("R1 led_q", led_q, 0);

        // R7: reads in both halves
        step(0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00);
        step(0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00);

        // R3: fixed build, lower-half write, ROM byte all ones
        step(0, 1'b0, 1'b0, 1'b0, 8'hB3, 8'hFF);
        idle(0);
        chk("R3 lower write prg", prg_hi, 5'h13);
        chk("R8 chr field", chr_bank, 1);
        chk("R8 mirror field", one_screen, 1);

        // R3: fixed build, upper-half write with conflicting ROM byte
        step(0, 1'b1, 1'b0, 1'b0, 8'hFF, 8'h2A);
        idle(0);
        chk("R3 conflict AND prg", prg_hi, 5'h0A);
        chk("R3 conflict AND chr", chr_bank, 1);
        chk("R10 fixed build led unchanged", led_q, 0);

        // R12: write line low without select
        step(0, 1'b0, 1'b0, 1'b1, 8'hC1, 8'hFF);
        idle(0);
        chk("R12 no select no load", prg_hi, 5'h0A);

        // R9: held strobe, data changes while held
        step(0, 1'b0, 1'b0, 1'b0, 8'h47, 8'hFF);
        step(0, 1'b0, 1'b0, 1'b0, 8'hF8, 8'hFF);
        step(0, 1'b1, 1'b0, 1'b0, 8'h99, 8'hFF);
        idle(0);
        chk("R9 held strobe loads once prg", prg_hi, 5'h07);
        chk("R9 held strobe loads once chr", chr_bank, 2);

        // R4: flashable build upper write, ROM byte zero
        step(1, 1'b1, 1'b0, 1'b0, 8'h5C, 8'h00);
        idle(1);
        chk("R4 no conflict prg", prg_hi, 5'h1C);
        chk("R4 no conflict chr", chr_bank, 2);

        // R5 and R10: lower-half write in flashable build
        step(1, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h00);
        idle(1);
        chk("R5 bank unchanged prg", prg_hi, 5'h1C);
        chk("R10 led latched", led_q, 8'hA5);

        // R10: upper write leaves indicator
        step(1, 1'b1, 1'b0, 1'b0, 8'h9F, 8'h00);
        idle(1);
        chk("R10 upper write keeps led", led_q, 8'hA5);
        chk("R11 bit4 dropped on small", prg_hi_s, 4'hF);
        chk("R11 full width prg", prg_hi, 5'h1F);
        chk("R8 mirror after flash load", one_screen, 1);

        // R11: bit 4 only
        step(1, 1'b1, 1'b0, 1'b0, 8'h10, 8'h00);
        idle(1);
        chk("R11 small ignores bit4", prg_hi_s, 0);

        // R9: held flash strobe latches once
        step(1, 1'b0, 1'b0, 1'b0, 8'h3C, 8'h00);
        step(1, 1'b0, 1'b0, 1'b0, 8'hC3, 8'h00);
        idle(1);
        chk("R9 held flash strobe", led_q, 8'h3C);

        // R1: reset again clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        exp_bank = 0; exp_led = 0; prev_kind = 0;
        @(negedge clk);
        rst_n = 1'b1;
        idle(0);
        chk("R1 reset clears led", led_q, 0);
        chk("R1 reset clears prg", prg_hi, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule